// File: doc/BRIEF.md
# Little-Endian Byte-Lane Load/Store Aligner

This block connects a processor datapath to a data memory that is one 32-bit word wide and byte addressable. A request carries a byte address, an access size of one, two or four bytes, and, for stores, the register value. The block sends the memory a word index and a byte-enable mask, and moves the store data into the byte lanes that the low address bits select. Byte order is little-endian: the address of a multi-byte item names its least significant byte, and lane k of the memory word holds bits 8k+7 down to 8k.

When a load completes, the memory word comes back with a valid strobe. The block uses the offset, size and signedness it saved when it accepted the load. It picks the addressed lanes, extends a byte or half-word to 32 bits with zeros or with copies of the sign bit, and presents the result one cycle later with its own strobe. An access whose address is not a whole multiple of its size is refused. No lane is enabled for it, and a single-cycle error pulse follows.

Top module: `lsu_lane_unit`

## Requirements
- R1: For an accepted request, `mem_waddr` equals `req_addr[31:2]`, so consecutive words are four byte addresses apart.
- R2: The size code is 00 for a byte, 01 for a half-word and 10 for a word. An accepted request enables lanes 0001<<off for a byte, 0011<<off for a half-word and 1111 for a word, where off = `req_addr[1:0]`.
- R3: A half-word at an odd address, a word at an address whose off is not zero, and any request with size code 11 are misaligned. Such a request leaves `mem_req` low and `mem_be` at 0000 in the same cycle.
- R4: `misalign_err` is high for exactly one cycle, the cycle after a misaligned request. It never rises after an aligned request or an idle cycle.
- R5: For a store, `mem_wdata` is the low 8 bits (byte), the low 16 bits (half-word) or all 32 bits (word) of `req_wdata`, shifted left by 8*off. All other bits are zero.
- R6: For a load with `req_signed`=0, `ld_data` is the selected byte or half-word of the returned word, starting at lane off, with zeros in the upper bits. A word load returns the whole word.
- R7: For a load with `req_signed`=1, a byte or half-word result copies its top bit into every upper bit of `ld_data`.
- R8: `ld_valid` pulses for one cycle, the cycle after `mem_rvalid`. `ld_data` is decoded using the most recent accepted load, and a refused load does not replace that saved context.
- R9: During reset, `misalign_err`, `ld_valid` and `ld_data` are zero.
- R10: An aligned request raises `mem_req` in the same cycle. `mem_we` is high only when `mem_req` and `req_write` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Size code: 00 byte, 01 half-word, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend a loaded byte or half-word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Register data for stores |
| mem_req | output | 1 | Request to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 30 | Word index |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data moved into lanes |
| mem_rvalid | input | 1 | Returned word is valid |
| mem_rdata | input | 32 | Returned memory word |
| misalign_err | output | 1 | One-cycle pulse after a refused request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
A stale saved offset or size would not show on the request side. It would appear as wrong data on the next `ld_valid` pulse, one cycle after the memory responds, so every load is followed straight through to its result. The bench also places a refused load between a load and its response, to show that the saved context survived. A wrong alignment decision shows in the same cycle on `mem_be` and `mem_req`, and again one cycle later as a missing or extra `misalign_err` pulse.

// File: rtl/lane_pkg.sv
package lane_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   typedef struct packed {
      logic [1:0] off;
      logic [1:0] size;
      logic       sgn;
   } ld_ctx_t;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [1:0]       size,
   input  logic [OFF_W-1:0] off,
   output logic             aligned,
   output logic [LANES-1:0] be
);
   import lane_pkg::*;

   logic [OFF_W:0] nbytes;
   logic [OFF_W:0] off_x;
   logic [OFF_W:0] end_x;

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: begin nbytes = (OFF_W+1)'(1); aligned = 1'b1;                 end
         SZ_HALF: begin nbytes = (OFF_W+1)'(2); aligned = (off[0] == 1'b0);      end
         SZ_WORD: begin nbytes = (OFF_W+1)'(4); aligned = (off == '0);           end
         default: begin nbytes = '0;            aligned = 1'b0;                  end
      endcase
   end

   assign off_x = {1'b0, off};
   assign end_x = off_x + nbytes;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [OFF_W:0] KV = (OFF_W+1)'(k);
      assign be[k] = aligned && (KV >= off_x) && (KV < end_x);
   end
endmodule

// File: rtl/lane_store_shift.sv
module lane_store_shift #(
   parameter int DATA_W = 32,
   localparam int OFF_W = $clog2(DATA_W/8)
) (
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   import lane_pkg::*;

   logic [DATA_W-1:0] trimmed;

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: trimmed = {{(DATA_W-8){1'b0}},  din[7:0]};
         SZ_HALF: trimmed = {{(DATA_W-16){1'b0}}, din[15:0]};
         default: trimmed = din;
      endcase
   end

   assign dout = trimmed << {off, 3'b000};
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract #(
   parameter int DATA_W      = 32,
   parameter bit SIGN_EXT_EN = 1'b1,
   localparam int OFF_W = $clog2(DATA_W/8)
) (
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic              sgn,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] dout
);
   import lane_pkg::*;

   logic [DATA_W-1:0] lowered;
   logic              fill_en;

   assign lowered = word >> {off, 3'b000};

   if (SIGN_EXT_EN) begin : g_sext
      assign fill_en = sgn;
   end else begin : g_zext
      assign fill_en = 1'b0;
   end

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: dout = {{(DATA_W-8){fill_en & lowered[7]}},   lowered[7:0]};
         SZ_HALF: dout = {{(DATA_W-16){fill_en & lowered[15]}}, lowered[15:0]};
         default: dout = word;
      endcase
   end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit SIGN_EXT_EN = 1'b1,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES),
   localparam int WA_W  = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WA_W-1:0]   mem_waddr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              misalign_err,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);
   import lane_pkg::*;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("lsu_lane_unit: DATA_W must be 32");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("lsu_lane_unit: ADDR_W too small");
   end

   logic [OFF_W-1:0]  off;
   logic              aligned;
   logic [LANES-1:0]  be_raw;
   logic              accept;
   ld_ctx_t           ctx_q;
   logic [DATA_W-1:0] ld_next;

   assign off = req_addr[OFF_W-1:0];

   lane_mask_gen #(.LANES(LANES)) u_mask (
      .size    (req_size),
      .off     (off),
      .aligned (aligned),
      .be      (be_raw)
   );

   lane_store_shift #(.DATA_W(DATA_W)) u_wshift (
      .size (req_size),
      .off  (off),
      .din  (req_wdata),
      .dout (mem_wdata)
   );

   assign accept    = req_valid && aligned;
   assign mem_req   = accept;
   assign mem_we    = accept && req_write;
   assign mem_be    = accept ? be_raw : '0;
   assign mem_waddr = req_addr[ADDR_W-1:OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_q <= '0;
      end else if (accept && !req_write) begin
         ctx_q.off  <= off;
         ctx_q.size <= req_size;
         ctx_q.sgn  <= req_signed;
      end
   end

   lane_load_extract #(.DATA_W(DATA_W), .SIGN_EXT_EN(SIGN_EXT_EN)) u_ldx (
      .size (ctx_q.size),
      .off  (ctx_q.off),
      .sgn  (ctx_q.sgn),
      .word (mem_rdata),
      .dout (ld_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         misalign_err <= 1'b0;
         ld_valid     <= 1'b0;
         ld_data      <= '0;
      end else begin
         misalign_err <= req_valid && !aligned;
         ld_valid     <= mem_rvalid;
         if (mem_rvalid) ld_data <= ld_next;
      end
   end
endmodule

// File: rtl/lane_unit_chk.sv
module lane_unit_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [1:0]       req_size,
   input logic [1:0]       a_off,
   input logic             mem_req,
   input logic             mem_we,
   input logic [LANES-1:0] mem_be,
   input logic             mem_rvalid,
   input logic             misalign_err,
   input logic             ld_valid
);
   // R3
   half_odd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == 2'b01 && a_off[0] |-> !mem_req && mem_be == '0);
   // R3
   idle_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> mem_be == '0);
   // R2
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && req_size == 2'b00 |-> $countones(mem_be) == 1);
   // R2
   word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && req_size == 2'b10 |-> &mem_be);
   // R4
   err_follows_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mem_req |=> misalign_err);
   // R4
   err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> $past(req_valid && !mem_req));
   // R8
   load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |=> ld_valid);
   // R8
   load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_rvalid));
   // R10
   we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req && req_write);
endmodule

bind lsu_lane_unit lane_unit_chk #(.LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_size     (req_size),
   .a_off        (req_addr[1:0]),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_be       (mem_be),
   .mem_rvalid   (mem_rvalid),
   .misalign_err (misalign_err),
   .ld_valid     (ld_valid)
);

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_we;
   logic [29:0] mem_waddr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        misalign_err, ld_valid;
   logic [31:0] ld_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];

   always #10 clk = ~clk;

   lsu_lane_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
      .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .misalign_err(misalign_err), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
      case (sz)
         2'b00:   return 4'b0001 << off;
         2'b01:   return 4'b0011 << off;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] d);
      case (sz)
         2'b00:   return {24'h0, d[7:0]}  << (8*off);
         2'b01:   return {16'h0, d[15:0]} << (8*off);
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] off,
                                          input logic sg, input logic [31:0] w);
      logic [31:0] b;
      b = w >> (8*off);
      case (sz)
         2'b00:   return sg ? {{24{b[7]}}, b[7:0]}   : {24'h0, b[7:0]};
         2'b01:   return sg ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]};
         default: return w;
      endcase
   endfunction

   function automatic bit is_aligned(input logic [1:0] sz, input logic [1:0] off);
      case (sz)
         2'b00:   return 1'b1;
         2'b01:   return off[0] == 1'b0;
         2'b10:   return off == 2'b00;
         default: return 1'b0;
      endcase
   endfunction

   // aligned store: R1 R2 R5 R10 checked combinationally, R4 one cycle later
   task automatic do_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
      #1;
      check("R10 mem_req", {31'h0, mem_req}, 32'h1);
      check("R10 mem_we", {31'h0, mem_we}, 32'h1);
      check("R1 waddr", {2'b00, mem_waddr}, {2'b00, a[31:2]});
      check("R2 be", {28'h0, mem_be}, {28'h0, exp_be(sz, a[1:0])});
      check("R5 wdata", mem_wdata, exp_wd(sz, a[1:0], d));
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 no err aligned", {31'h0, misalign_err}, 32'h0);
   endtask

   // misaligned request: R3 same cycle, R4 pulse next cycle then gone
   task automatic do_bad(input logic [31:0] a, input logic [1:0] sz, input logic wr);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = 32'hFFFF_FFFF;
      #1;
      check("R3 mem_req low", {31'h0, mem_req}, 32'h0);
      check("R3 be zero", {28'h0, mem_be}, 32'h0);
      check("R10 we low", {31'h0, mem_we}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 err pulse", {31'h0, misalign_err}, 32'h1);
      @(negedge clk);
      check("R4 err single", {31'h0, misalign_err}, 32'h0);
   endtask

   // load: request, optional refused load in between, then memory response
   task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input logic sg,
                          input logic [31:0] w, input bit interpose);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_signed = sg; req_addr = a;
      #1;
      check("R10 load mem_req", {31'h0, mem_req}, 32'h1);
      check("R10 load mem_we", {31'h0, mem_we}, 32'h0);
      check("R1 load waddr", {2'b00, mem_waddr}, {2'b00, a[31:2]});
      @(negedge clk);
      req_valid = 1'b0;
      if (interpose) begin
         req_valid = 1'b1; req_size = 2'b10; req_addr = a | 32'h1; req_signed = ~sg;
         @(negedge clk);
         req_valid = 1'b0;
         check("R8 refused load err", {31'h0, misalign_err}, 32'h1);
      end
      mem_rvalid = 1'b1; mem_rdata = w;
      exp_q.push_back(exp_ld(sz, a[1:0], sg, w));
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      @(negedge clk);
      check("R8 single ld_valid", {31'h0, ld_valid}, 32'h0);
   endtask

   // monitor: scoreboard compare on each load result
   always @(negedge clk) begin
      if (rst_n && ld_valid) begin
         if (exp_q.size() == 0) begin
            check("R8 unexpected ld_valid", 32'h1, 32'h0);
         end else begin
            check("R6 R7 ld_data", ld_data, exp_q.pop_front());
         end
      end
   end

   bit finished = 1'b0;
   initial begin
      #(200000 * 20);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R9 reset values
      check("R9 err reset", {31'h0, misalign_err}, 32'h0);
      check("R9 ld_valid reset", {31'h0, ld_valid}, 32'h0);
      check("R9 ld_data reset", ld_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R5 stores at every lane
      for (int o = 0; o < 4; o++) do_store(32'h1000_0040 + o, 2'b00, 32'hA1B2_C3D4);
      do_store(32'h2000_0100, 2'b01, 32'h1234_5678);
      do_store(32'h2000_0102, 2'b01, 32'h9ABC_DEF0);
      do_store(32'hFFFF_FFFC, 2'b10, 32'hCAFE_F00D);

      // R3 R4 misaligned forms and reserved size
      do_bad(32'h0000_0011, 2'b01, 1'b1);
      do_bad(32'h0000_0013, 2'b01, 1'b0);
      for (int o = 1; o < 4; o++) do_bad(32'h0000_0020 + o, 2'b10, 1'b1);
      do_bad(32'h0000_0030, 2'b11, 1'b1);

      // R6 unsigned, R7 signed loads
      for (int o = 0; o < 4; o++) begin
         do_load(32'h3000_0000 + o, 2'b00, 1'b0, 32'h80F1_7F9A, 1'b0);
         do_load(32'h3000_0000 + o, 2'b00, 1'b1, 32'h80F1_7F9A, 1'b0);
      end
      do_load(32'h3000_0004, 2'b01, 1'b0, 32'h8001_F234, 1'b0);
      do_load(32'h3000_0006, 2'b01, 1'b0, 32'h8001_F234, 1'b0);
      do_load(32'h3000_0004, 2'b01, 1'b1, 32'h8001_F234, 1'b0);
      do_load(32'h3000_0006, 2'b01, 1'b1, 32'h8001_F234, 1'b0);
      do_load(32'h3000_0006, 2'b01, 1'b1, 32'h7FFF_0000, 1'b0);
      do_load(32'h3000_0008, 2'b10, 1'b1, 32'h8765_4321, 1'b0);
      // R8 refused load between does not disturb saved context
      do_load(32'h3000_0003, 2'b00, 1'b1, 32'h8100_0000, 1'b1);
      do_load(32'h3000_0002, 2'b01, 1'b0, 32'hFEDC_0000, 1'b1);

      repeat (3) @(negedge clk);
      check("R8 all loads returned", exp_q.size(), 32'h0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule